// File: doc/BRIEF.md
# Programmable Horizontal Display Timing Generator

This block runs a pixel-clock horizontal counter and derives a horizontal blanking output and a horizontal sync output from transition points that software programs. Every transition point is stored as the pixel count at which the output changes, minus one, at single-pixel resolution. A separate line-length value sets the last count of each line before the counter returns to zero.

The sync output also drives the vertical side of the display. On the clock where sync goes active, the block raises a one-cycle advance pulse and steps a line counter. The line counter therefore follows the sync edge and not the counter wrap, so the sync points must be programmed even for a display that never uses the sync pin. The block checks the programmed sync placement against a minimum width and a minimum distance after the blank start, and raises an error flag if either rule is broken. The outputs keep running with the values as programmed.

Software writes go into shadow copies. The shadow copies move into the active set only at the end of a line, so a write made mid-line never changes the line in progress.

Top module: `hdt_timing_top`

## Requirements
- R1: While reset is asserted and on the first clock after it, `hcount` is 0, and `blank`, `hsync`, `line_adv` and `line` are all 0.
- R2: `hcount` steps by one each clock from 0 up to the active line-length value, then returns to 0. The line-length value is written at address 2, bits 11:0.
- R3: Address 0 holds the blank points and address 1 holds the sync points. In both, the end point sits in bits 27:16 and the start point in bits 11:0. Bits 31:28 and 15:12 have no effect on any output.
- R4: With blank start S and blank end E, where S < E and E is at most the line length, `blank` is 1 exactly while S < `hcount` <= E. Any pixel value is valid.
- R5: With sync start S and sync end E, where S < E and E is at most the line length, `hsync` is 1 exactly while S < `hcount` <= E.
- R6: `line_adv` is 1 for exactly one clock per sync pulse. That clock is the one in which `hsync` first reads 1, which is where `hcount` equals the sync start plus 1.
- R7: `line` increases by one, modulo 2^11, on the clock after each `line_adv` pulse, and changes at no other time.
- R8: A write changes only a shadow copy. The new value takes effect from the first `hcount` = 0 after the next wrap. The line in progress uses the old values.
- R9: `err` is 1 when the active sync width (sync end minus sync start, modulo 4096) is below 8, or when the sync start is below the blank start plus 8. Otherwise it is 0. `blank` and `hsync` follow the programmed points either way.
- R10: When a start point equals its end point, that output stays 0 for the whole line, and for sync no `line_adv` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 blank, 1 sync, 2 line length |
| wr_data | input | 32 | Write data |
| hcount | output | 12 | Horizontal pixel counter |
| blank | output | 1 | Horizontal blanking, active high |
| hsync | output | 1 | Horizontal sync, active high |
| line_adv | output | 1 | One-cycle vertical advance pulse |
| line | output | 11 | Line counter, stepped by sync |
| err | output | 1 | Sync placement rule violated |

## Verification
The bench places sync exactly at the legal limits: a gap of 8 after the blank start and a width of 8. It then moves each one down by a single pixel, so a design that compares with an off-by-one or a strict inequality flags the wrong case. It puts junk in the reserved bits, and a design that decodes too wide a field then moves its edges. It writes new sync points mid-line, and a design without shadowing then changes the current line. Last, it programs equal start and end points, where a design that gives set priority would latch sync high and step the line counter.

// File: rtl/hdt_pkg.sv
package hdt_pkg;
   typedef enum logic [1:0] {
      SEL_BLANK = 2'd0,
      SEL_SYNC  = 2'd1,
      SEL_TOTAL = 2'd2
   } hdt_sel_e;

   localparam int unsigned HDT_END_LSB = 16;
endpackage

// File: rtl/hdt_shadow_regs.sv
module hdt_shadow_regs
   import hdt_pkg::*;
#(
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load_i,
   output logic [CNT_W-1:0]  blk_s_o,
   output logic [CNT_W-1:0]  blk_e_o,
   output logic [CNT_W-1:0]  syn_s_o,
   output logic [CNT_W-1:0]  syn_e_o,
   output logic [CNT_W-1:0]  total_o
);
   localparam int unsigned END_LSB = HDT_END_LSB;
   localparam logic [DATA_W-1:0] FIELD_MASK =
      (DATA_W'((1 << CNT_W) - 1)) | (DATA_W'((1 << CNT_W) - 1) << END_LSB);

   logic [CNT_W-1:0] sh_blk_s, sh_blk_e, sh_syn_s, sh_syn_e, sh_total;
   logic [CNT_W-1:0] f_lo, f_hi;
   logic             rsvd_unused;

   assign f_lo        = wr_data[CNT_W-1:0];
   assign f_hi        = wr_data[END_LSB +: CNT_W];
   assign rsvd_unused = ^(wr_data & ~FIELD_MASK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_blk_s <= '0;
         sh_blk_e <= '0;
         sh_syn_s <= '0;
         sh_syn_e <= '0;
         sh_total <= '0;
      end else if (wr_en) begin
         case (hdt_sel_e'(wr_addr))
            SEL_BLANK: begin
               sh_blk_s <= f_lo;
               sh_blk_e <= f_hi;
            end
            SEL_SYNC: begin
               sh_syn_s <= f_lo;
               sh_syn_e <= f_hi;
            end
            SEL_TOTAL: sh_total <= f_lo;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_s_o <= '0;
         blk_e_o <= '0;
         syn_s_o <= '0;
         syn_e_o <= '0;
         total_o <= '0;
      end else if (load_i) begin
         blk_s_o <= sh_blk_s;
         blk_e_o <= sh_blk_e;
         syn_s_o <= sh_syn_s;
         syn_e_o <= sh_syn_e;
         total_o <= sh_total;
      end
   end

   assert_active_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load_i) |-> ($stable(syn_s_o) && $stable(syn_e_o) && $stable(blk_s_o)
                          && $stable(blk_e_o) && $stable(total_o)));
endmodule

// File: rtl/hdt_edge_gen.sv
module hdt_edge_gen #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] start_i,
   input  logic [CNT_W-1:0] stop_i,
   output logic             level_o,
   output logic             rise_o
);
   logic hit_start, hit_stop;

   assign hit_start = (cnt_i == start_i);
   assign hit_stop  = (cnt_i == stop_i);

   // clear takes priority so equal points leave the output inactive
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_o <= 1'b0;
         rise_o  <= 1'b0;
      end else begin
         if (hit_stop)       level_o <= 1'b0;
         else if (hit_start) level_o <= 1'b1;
         rise_o <= hit_start && !hit_stop && !level_o;
      end
   end

   assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
   assert_rise_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |-> (level_o && !$past(level_o)));
endmodule

// File: rtl/hdt_rule_chk.sv
module hdt_rule_chk #(
   parameter int unsigned CNT_W     = 12,
   parameter int unsigned MIN_WIDTH = 8,
   parameter int unsigned MIN_GAP   = 8,
   parameter bit          CHECK_EN  = 1'b1
) (
   input  logic [CNT_W-1:0] blk_s_i,
   input  logic [CNT_W-1:0] syn_s_i,
   input  logic [CNT_W-1:0] syn_e_i,
   output logic             err_o
);
   localparam logic [CNT_W-1:0] WIDTH_LIM = CNT_W'(MIN_WIDTH);
   localparam logic [CNT_W:0]   GAP_LIM   = (CNT_W + 1)'(MIN_GAP);

   generate
      if (CHECK_EN) begin : g_check
         logic [CNT_W-1:0] width;
         logic             narrow, early;
         assign width  = syn_e_i - syn_s_i;
         assign narrow = (width < WIDTH_LIM);
         assign early  = ({1'b0, syn_s_i} < ({1'b0, blk_s_i} + GAP_LIM));
         assign err_o  = narrow || early;
      end else begin : g_nocheck
         logic inputs_unused;
         assign inputs_unused = ^{blk_s_i, syn_s_i, syn_e_i};
         assign err_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/hdt_timing_top.sv
module hdt_timing_top
   import hdt_pkg::*;
#(
   parameter int unsigned CNT_W     = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LINE_W    = 11,
   parameter int unsigned MIN_WIDTH = 8,
   parameter int unsigned MIN_GAP   = 8,
   parameter bit          CHECK_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  hcount,
   output logic              blank,
   output logic              hsync,
   output logic              line_adv,
   output logic [LINE_W-1:0] line,
   output logic              err
);
   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
   localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

   initial begin
      assert (CNT_W >= 4 && CNT_W <= HDT_END_LSB)
         else $error("CNT_W out of range");
      assert (DATA_W >= HDT_END_LSB + CNT_W)
         else $error("DATA_W too narrow for field layout");
      assert (MIN_WIDTH < (1 << CNT_W) && MIN_GAP < (1 << CNT_W))
         else $error("rule limits exceed counter range");
      assert (LINE_W >= 1) else $error("LINE_W must be positive");
   end

   logic [CNT_W-1:0] a_blk_s, a_blk_e, a_syn_s, a_syn_e, a_total;
   logic             wrap;
   logic             blank_rise;

   assign wrap = (hcount == a_total);

   hdt_shadow_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .load_i(wrap),
      .blk_s_o(a_blk_s), .blk_e_o(a_blk_e),
      .syn_s_o(a_syn_s), .syn_e_o(a_syn_e), .total_o(a_total)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)    hcount <= '0;
      else if (wrap) hcount <= '0;
      else           hcount <= hcount + CNT_ONE;
   end

   hdt_edge_gen #(.CNT_W(CNT_W)) u_blank (
      .clk(clk), .rst_n(rst_n), .cnt_i(hcount),
      .start_i(a_blk_s), .stop_i(a_blk_e),
      .level_o(blank), .rise_o(blank_rise)
   );

   hdt_edge_gen #(.CNT_W(CNT_W)) u_sync (
      .clk(clk), .rst_n(rst_n), .cnt_i(hcount),
      .start_i(a_syn_s), .stop_i(a_syn_e),
      .level_o(hsync), .rise_o(line_adv)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        line <= '0;
      else if (line_adv) line <= line + LINE_ONE;
   end

   hdt_rule_chk #(
      .CNT_W(CNT_W), .MIN_WIDTH(MIN_WIDTH), .MIN_GAP(MIN_GAP), .CHECK_EN(CHECK_EN)
   ) u_rules (
      .blk_s_i(a_blk_s), .syn_s_i(a_syn_s), .syn_e_i(a_syn_e), .err_o(err)
   );

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hcount != '0) |-> (hcount == $past(hcount) + CNT_ONE));
   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hcount <= a_total);
   assert_blank_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      blank_rise |-> (blank && !$past(blank)));
   assert_line_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(line_adv) |-> (line == $past(line) + LINE_ONE));
   assert_line_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(line_adv) |-> $stable(line));
endmodule

// File: tb/tb_hdt_timing_top.sv
module tb_hdt_timing_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [11:0] hcount;
   logic        blank, hsync, line_adv, err;
   logic [10:0] line;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   hdt_timing_top dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .hcount(hcount), .blank(blank), .hsync(hsync),
      .line_adv(line_adv), .line(line), .err(err)
   );

   function automatic bit in_win(int h, int s, int e);
      return (s < e) && (h > s) && (h <= e);
   endfunction

   function automatic bit rule_err(int bs, int ss, int se);
      int w;
      w = (se - ss) & 12'hFFF;
      return (w < 8) || (ss < bs + 8);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic prog(int bs, int be, int ss, int se, int tot, logic [31:0] junk);
      wr(2'd0, ((32'(be) & 32'hFFF) << 16) | (32'(bs) & 32'hFFF) | junk);
      wr(2'd1, ((32'(se) & 32'hFFF) << 16) | (32'(ss) & 32'hFFF) | junk);
      wr(2'd2, (32'(tot) & 32'hFFF) | junk);
      // move to the line whose start loads these values
      while (hcount == 12'd0) @(negedge clk);
      while (hcount != 12'd0) @(negedge clk);
   endtask

   // entered at a negedge with hcount == 0; leaves at hcount == 0 of the next line
   task automatic run_line(int bs, int be, int ss, int se, int tot,
                           bit mid_en, int mid, logic [1:0] ma, logic [31:0] md);
      int adv_n;
      int l0;
      bit e_err;
      adv_n = 0;
      l0 = int'(line);
      e_err = rule_err(bs, ss, se);
      for (int i = 0; i <= tot; i++) begin
         if (hcount != 12'(i)) begin
            chk(1'b0, "R2 hcount", int'(hcount), i);
            return;
         end
         if (blank != in_win(i, bs, be)) chk(1'b0, "R4 blank", blank, in_win(i, bs, be));
         if (hsync != in_win(i, ss, se)) chk(1'b0, "R5 hsync", hsync, in_win(i, ss, se));
         if (line_adv != ((ss < se) && (i == ss + 1)))
            chk(1'b0, "R6 line_adv", line_adv, (ss < se) && (i == ss + 1));
         if (err != e_err) chk(1'b0, "R9 err", err, e_err);
         if (line_adv) adv_n++;
         if (mid_en && i == mid) begin
            wr_en = 1'b1; wr_addr = ma; wr_data = md;
         end else begin
            wr_en = 1'b0;
         end
         @(negedge clk);
      end
      wr_en = 1'b0;
      chk(hcount == 12'd0, "R2 wrap", int'(hcount), 0);
      chk(adv_n == ((ss < se) ? 1 : 0), "R6/R10 pulses per line", adv_n, (ss < se) ? 1 : 0);
      chk(int'(line) == ((l0 + adv_n) & 11'h7FF), "R7 line step", int'(line), (l0 + adv_n) & 11'h7FF);
      chk(1'b1, "R4/R5 line windows", 0, 0);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int bs, be, ss, se, tot;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1: values during reset
      chk(hcount == 0 && !blank && !hsync && !line_adv && line == 0, "R1 in reset",
          {hcount, blank, hsync, line_adv}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(hcount == 0 && !blank && !hsync && !line_adv && line == 0, "R1 after reset",
          {hcount, blank, hsync, line_adv}, 0);

      // legal limits: gap 8, width 8 (R4, R5, R9)
      prog(79, 99, 87, 95, 99, 32'h0);
      run_line(79, 99, 87, 95, 99, 1'b0, 0, 2'd0, 32'h0);
      run_line(79, 99, 87, 95, 99, 1'b0, 0, 2'd0, 32'h0);

      // gap 7: rule broken, outputs still follow (R9)
      prog(79, 99, 86, 95, 99, 32'h0);
      run_line(79, 99, 86, 95, 99, 1'b0, 0, 2'd0, 32'h0);
      // width 7 (R9)
      prog(79, 99, 88, 95, 99, 32'h0);
      run_line(79, 99, 88, 95, 99, 1'b0, 0, 2'd0, 32'h0);

      // reserved bits full of junk (R3)
      prog(30, 61, 45, 53, 70, 32'hF000_F000);
      run_line(30, 61, 45, 53, 70, 1'b0, 0, 2'd0, 32'h0);

      // mid-line write of new sync points is deferred (R8)
      run_line(30, 61, 45, 53, 70, 1'b1, 20, 2'd1, (32'd66 << 16) | 32'd50);
      run_line(30, 61, 50, 66, 70, 1'b0, 0, 2'd0, 32'h0);

      // equal sync points: no pulse, no line step (R10)
      prog(10, 40, 55, 55, 80, 32'h0);
      run_line(10, 40, 55, 55, 80, 1'b0, 0, 2'd0, 32'h0);
      // odd pixel positions (R4, R5)
      prog(3, 77, 13, 101, 101, 32'h0);
      run_line(3, 77, 13, 101, 101, 1'b0, 0, 2'd0, 32'h0);

      // constrained random configurations
      for (int k = 0; k < 14; k++) begin
         tot = 40 + int'($urandom % 260);
         bs  = int'($urandom % tot);
         be  = bs + 1 + int'($urandom % (tot - bs));
         ss  = int'($urandom % tot);
         se  = ss + 1 + int'($urandom % (tot - ss));
         prog(bs, be, ss, se, tot, ($urandom % 2) ? 32'hA000_5000 : 32'h0);
         run_line(bs, be, ss, se, tot, 1'b0, 0, 2'd0, 32'h0);
         run_line(bs, be, ss, se, tot, 1'b0, 0, 2'd0, 32'h0);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule